// File: doc/BRIEF.md
# Trace Buffer Pointer and Watermark Controller

This block steers where an execution-trace source writes its packets inside a region of system RAM. Each trace packet takes one 8-byte slot. The block keeps a packet pointer, and every packet strobe accepted while tracing is on writes at that pointer and then moves it on by one slot. The pointer runs inside a power-of-two window chosen by a 5-bit size field. When the low part of the pointer rolls over to zero, a sticky wrap flag is set.

Tracing is switched on and off in three ways: by software through the control word, by two external trigger inputs when each is enabled, or automatically. For the automatic case, software programs a watermark slot. When the pointer sits on that slot while tracing is on, the block can turn tracing off, raise a sticky debug halt request, or do both.

A simple select/write port gives software access to the position, control and flow words, and to a fixed read-only base word. The base word is derived from the RAM size parameter.

Top module: `trc_ptr_ctrl`

## Requirements
- R1: After reset every register field is zero, so position, control and flow all read 0, and `ram_we` and `halt_req` are 0.
- R2: Register access uses `reg_sel` as follows.
  - Select 0 is position: pointer in bits 31:3 and wrap flag in bit 2.
  - Select 1 is control: size field in 4:0, start-trigger enable in 5, stop-trigger enable in 6, halt in 9, trace enable in 31.
  - Select 2 is flow: auto-stop in 0, auto-halt in 1, watermark in 31:3.
  - Select 3 returns the constant 0x2000_0000 − RAM_BYTES/4, and writes to it are ignored.
  - All other bits read 0.
- R3: `ram_we` equals `pkt_wr` while trace enable is 1 and is 0 otherwise. In the same cycle, `ram_addr` equals the pointer shifted left by 3.
- R4: Each accepted packet advances the pointer in the next cycle. With size field M, the low min(M+1, 29) pointer bits increment modulo their range, and the bits above them keep their value.
- R5: The wrap flag becomes 1 when an accepted packet rolls the low field from all-ones to zero. It stays set until software writes it. A packet strobe while tracing is off changes neither the pointer nor the flag.
- R6: A start trigger with its enable set turns tracing on. A stop trigger with its enable set turns it off, and stop wins when both occur together. A trigger whose enable bit is 0 has no effect.
- R7: While tracing is on, the pointer equals the watermark and auto-stop is 1, trace enable is 0 in the next cycle. This overrides a start trigger.
- R8: While tracing is on, the pointer equals the watermark and auto-halt is 1, the halt bit is set in the next cycle and stays set until software writes it. `halt_req` always shows the halt bit.
- R9: A software write to a register takes effect in the next cycle over any automatic update of that register in the same cycle (packet advance, wrap, trigger, watermark action).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_wr | input | 1 | Packet write strobe from the trace source |
| trig_start | input | 1 | External start trigger |
| trig_stop | input | 1 | External stop trigger |
| reg_sel | input | 2 | Register select (0 position, 1 control, 2 flow, 3 base) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ram_addr | output | 32 | Byte address of the current packet slot |
| ram_we | output | 1 | RAM write enable for the packet |
| halt_req | output | 1 | Debug halt request |

## Verification
The bench builds the block with RAM_BYTES set to 32768, so the base word must read 0x1FFF_E000 rather than the default value. Random control writes keep the size field mostly between 0 and 5, so the window rolls over every 2 to 64 packets and wrap events and watermark hits occur often within a few thousand cycles. Occasional size values of 28 and above cover the clamp at the full pointer width. Directed sequences cover stop-over-start priority, disabled triggers, and software writes that collide with packet advances and trigger events.

// File: rtl/trc_ptr_pkg.sv
package trc_ptr_pkg;

    localparam int DATA_W   = 32;
    localparam int SLOT_LSB = 3;
    localparam int PTR_W    = DATA_W - SLOT_LSB;
    localparam int MASK_W   = 5;

    localparam int CTL_START_BIT = 5;
    localparam int CTL_STOP_BIT  = 6;
    localparam int CTL_HALT_BIT  = 9;
    localparam int CTL_EN_BIT    = 31;
    localparam int POS_WRAP_BIT  = 2;
    localparam int FLW_STOP_BIT  = 0;
    localparam int FLW_HALT_BIT  = 1;

    typedef enum logic [1:0] {
        SEL_POS  = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_FLOW = 2'd2,
        SEL_BASE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic              wrap;
        logic [MASK_W-1:0] size;
        logic              start_en;
        logic              stop_en;
        logic              halt;
        logic              en;
        logic              auto_stop;
        logic              auto_halt;
        logic [PTR_W-1:0]  wmark;
    } trc_state_t;

endpackage

// File: rtl/trc_wrap_step.sv
module trc_wrap_step #(
    parameter int PTR_W  = 29,
    parameter int MASK_W = 5
) (
    input  logic [PTR_W-1:0]  ptr_q,
    input  logic [MASK_W-1:0] size,
    output logic [PTR_W-1:0]  ptr_d,
    output logic [PTR_W-1:0]  low_mask,
    output logic              rolls
);
    logic [PTR_W-1:0] inc;

    // Window mask: bit i belongs to the counting field when i <= size.
    for (genvar gi = 0; gi < PTR_W; gi++) begin : g_mask
        assign low_mask[gi] = (gi <= int'(size));
    end

    always_comb begin
        inc   = ptr_q + {{(PTR_W-1){1'b0}}, 1'b1};
        ptr_d = (ptr_q & ~low_mask) | (inc & low_mask);
        rolls = ((ptr_q & low_mask) == low_mask);
    end
endmodule

// File: rtl/trc_run_ctl.sv
module trc_run_ctl (
    input  logic en_q,
    input  logic start_en,
    input  logic stop_en,
    input  logic trig_start,
    input  logic trig_stop,
    input  logic wm_stop,
    output logic en_d
);
    logic go;
    logic halt_run;

    always_comb begin
        go       = start_en && trig_start;
        halt_run = (stop_en && trig_stop) || wm_stop;
        en_d     = en_q;
        if (go)       en_d = 1'b1;
        if (halt_run) en_d = 1'b0;
    end
endmodule

// File: rtl/trc_ptr_ctrl.sv
module trc_ptr_ctrl
    import trc_ptr_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 16384
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_wr,
    input  logic              trig_start,
    input  logic              trig_stop,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] ram_addr,
    output logic              ram_we,
    output logic              halt_req
);
    localparam logic [DATA_W-1:0] BASE_WORD = 32'h2000_0000 - DATA_W'(RAM_BYTES / 4);

    trc_state_t       s_q, s_d;
    logic [PTR_W-1:0] step_ptr;
    logic [PTR_W-1:0] win_mask;
    logic             step_roll;
    logic             run_en_d;
    logic             accept;
    logic             wm_hit;
    reg_sel_e         sel;

    assign sel    = reg_sel_e'(reg_sel);
    assign accept = pkt_wr && s_q.en;
    assign wm_hit = s_q.en && (s_q.ptr == s_q.wmark);

    trc_wrap_step #(.PTR_W(PTR_W), .MASK_W(MASK_W)) u_step (
        .ptr_q    (s_q.ptr),
        .size     (s_q.size),
        .ptr_d    (step_ptr),
        .low_mask (win_mask),
        .rolls    (step_roll)
    );

    trc_run_ctl u_run (
        .en_q       (s_q.en),
        .start_en   (s_q.start_en),
        .stop_en    (s_q.stop_en),
        .trig_start (trig_start),
        .trig_stop  (trig_stop),
        .wm_stop    (wm_hit && s_q.auto_stop),
        .en_d       (run_en_d)
    );

    always_comb begin
        s_d    = s_q;
        s_d.en = run_en_d;
        if (accept) begin
            s_d.ptr = step_ptr;
            if (step_roll) s_d.wrap = 1'b1;
        end
        if (wm_hit && s_q.auto_halt) s_d.halt = 1'b1;
        // Software access overrides every automatic update above.
        if (reg_wr) begin
            unique case (sel)
                SEL_POS: begin
                    s_d.ptr  = reg_wdata[DATA_W-1:SLOT_LSB];
                    s_d.wrap = reg_wdata[POS_WRAP_BIT];
                end
                SEL_CTL: begin
                    s_d.size     = reg_wdata[MASK_W-1:0];
                    s_d.start_en = reg_wdata[CTL_START_BIT];
                    s_d.stop_en  = reg_wdata[CTL_STOP_BIT];
                    s_d.halt     = reg_wdata[CTL_HALT_BIT];
                    s_d.en       = reg_wdata[CTL_EN_BIT];
                end
                SEL_FLOW: begin
                    s_d.wmark     = reg_wdata[DATA_W-1:SLOT_LSB];
                    s_d.auto_stop = reg_wdata[FLW_STOP_BIT];
                    s_d.auto_halt = reg_wdata[FLW_HALT_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_POS: begin
                reg_rdata[DATA_W-1:SLOT_LSB] = s_q.ptr;
                reg_rdata[POS_WRAP_BIT]      = s_q.wrap;
            end
            SEL_CTL: begin
                reg_rdata[MASK_W-1:0]    = s_q.size;
                reg_rdata[CTL_START_BIT] = s_q.start_en;
                reg_rdata[CTL_STOP_BIT]  = s_q.stop_en;
                reg_rdata[CTL_HALT_BIT]  = s_q.halt;
                reg_rdata[CTL_EN_BIT]    = s_q.en;
            end
            SEL_FLOW: begin
                reg_rdata[DATA_W-1:SLOT_LSB] = s_q.wmark;
                reg_rdata[FLW_STOP_BIT]      = s_q.auto_stop;
                reg_rdata[FLW_HALT_BIT]      = s_q.auto_halt;
            end
            default: reg_rdata = BASE_WORD;
        endcase
    end

    assign ram_addr = {s_q.ptr, {SLOT_LSB{1'b0}}};
    assign ram_we   = accept;
    assign halt_req = s_q.halt;

    AST_HIGH_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !reg_wr) |=> ((s_q.ptr & ~$past(win_mask)) == ($past(s_q.ptr) & ~$past(win_mask)))) // R4
        else $error("pointer bits above the window changed");
    AST_IDLE_PTR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we && !reg_wr) |=> $stable(s_q.ptr)) // R5
        else $error("pointer moved without an accepted packet");
    AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.wrap && !reg_wr) |=> s_q.wrap) // R5
        else $error("wrap flag cleared without a write");
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_stop && s_q.stop_en && !reg_wr) |=> !s_q.en) // R6
        else $error("enabled stop trigger did not stop tracing");
    AST_WM_AUTOSTOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wm_hit && s_q.auto_stop && !reg_wr) |=> !s_q.en) // R7
        else $error("watermark auto-stop missed");
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !reg_wr) |=> halt_req) // R8
        else $error("halt request dropped without a write");
endmodule

// File: tb/tb_trc_ptr_ctrl.sv
module tb_trc_ptr_ctrl;
    localparam int unsigned RAM_BYTES = 32768;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_wr = 1'b0, trig_start = 1'b0, trig_stop = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata, ram_addr;
    logic        ram_we, halt_req;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the register state
    logic [28:0] m_ptr, m_wm;
    logic        m_wrap, m_sen, m_ten, m_halt, m_en, m_as, m_ah;
    logic [4:0]  m_size;

    trc_ptr_ctrl #(.RAM_BYTES(RAM_BYTES)) dut (
        .clk(clk), .rst_n(rst_n), .pkt_wr(pkt_wr), .trig_start(trig_start),
        .trig_stop(trig_stop), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_addr(ram_addr),
        .ram_we(ram_we), .halt_req(halt_req)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] ctl_word(logic en, logic halt, logic ten, logic sen, logic [4:0] sz);
        return {en, 21'b0, halt, 2'b00, ten, sen, sz};
    endfunction

    function automatic logic [31:0] flow_word(logic [28:0] wm, logic ah, logic as_);
        return {wm, 1'b0, ah, as_};
    endfunction

    function automatic logic [28:0] win(logic [4:0] sz);
        logic [28:0] r;
        for (int i = 0; i < 29; i++) r[i] = (i <= int'(sz));
        return r;
    endfunction

    function automatic logic [31:0] exp_read(logic [1:0] sel);
        case (sel)
            2'd0:    return {m_ptr, m_wrap, 2'b00};
            2'd1:    return ctl_word(m_en, m_halt, m_ten, m_sen, m_size);
            2'd2:    return flow_word(m_wm, m_ah, m_as);
            default: return 32'h2000_0000 - RAM_BYTES / 4;
        endcase
    endfunction

    task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ptr = '0; m_wm = '0; m_wrap = 0; m_sen = 0; m_ten = 0;
        m_halt = 0; m_en = 0; m_as = 0; m_ah = 0; m_size = '0;
    endtask

    // One clock cycle: drive, check combinational outputs, advance the model.
    task automatic cyc(logic pw, logic ts, logic tp, logic [1:0] sel,
                       logic wr, logic [31:0] wd, string tag);
        logic [28:0] lm, n_ptr, n_wm;
        logic n_wrap, n_sen, n_ten, n_halt, n_en, n_as, n_ah, hit;
        logic [4:0] n_size;
        @(negedge clk);
        pkt_wr = pw; trig_start = ts; trig_stop = tp;
        reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        #1;
        chk(ram_we === (pw && m_en), "R3 ram_we", {31'b0, ram_we}, {31'b0, pw && m_en});
        chk(ram_addr === {m_ptr, 3'b000}, "R3 ram_addr", ram_addr, {m_ptr, 3'b000});
        chk(reg_rdata === exp_read(sel), tag, reg_rdata, exp_read(sel));
        chk(halt_req === m_halt, "R8 halt_req", {31'b0, halt_req}, {31'b0, m_halt});
        hit = m_en && (m_ptr == m_wm);
        n_ptr = m_ptr; n_wm = m_wm; n_wrap = m_wrap; n_sen = m_sen; n_ten = m_ten;
        n_halt = m_halt; n_en = m_en; n_as = m_as; n_ah = m_ah; n_size = m_size;
        if (pw && m_en) begin
            lm = win(m_size);
            n_ptr = (m_ptr & ~lm) | ((m_ptr + 29'd1) & lm);
            if ((m_ptr & lm) == lm) n_wrap = 1'b1;
        end
        if (m_sen && ts) n_en = 1'b1;
        if (m_ten && tp) n_en = 1'b0;
        if (hit && m_as) n_en = 1'b0;
        if (hit && m_ah) n_halt = 1'b1;
        if (wr) begin
            case (sel)
                2'd0: begin n_ptr = wd[31:3]; n_wrap = wd[2]; end
                2'd1: begin n_size = wd[4:0]; n_sen = wd[5]; n_ten = wd[6];
                            n_halt = wd[9]; n_en = wd[31]; end
                2'd2: begin n_wm = wd[31:3]; n_as = wd[0]; n_ah = wd[1]; end
                default: ;
            endcase
        end
        @(posedge clk);
        m_ptr = n_ptr; m_wm = n_wm; m_wrap = n_wrap; m_sen = n_sen; m_ten = n_ten;
        m_halt = n_halt; m_en = n_en; m_as = n_as; m_ah = n_ah; m_size = n_size;
    endtask

    task automatic rd(logic [1:0] sel, string tag);
        cyc(1'b0, 1'b0, 1'b0, sel, 1'b0, 32'h0, tag);
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] d, string tag);
        cyc(1'b0, 1'b0, 1'b0, sel, 1'b1, d, tag);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int s = 0; s < 4; s++) rd(2'(s), "R1 reset read");

        // R2: base word is read-only
        wr(2'd3, 32'hDEAD_BEEF, "R2 base write");
        rd(2'd3, "R2 base read");

        // R4 / R5: small window, rollover and sticky wrap
        wr(2'd0, {29'h0000_0105, 1'b0, 2'b00}, "R4 pos write");
        wr(2'd1, ctl_word(1'b1, 1'b0, 1'b0, 1'b0, 5'd1), "R4 ctl write");
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, "R4 window advance");
        rd(2'd0, "R5 wrap sticky");

        // R5: packets ignored while disabled
        wr(2'd1, ctl_word(1'b0, 1'b0, 1'b0, 1'b0, 5'd3), "R5 disable");
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, "R5 disabled packets");

        // R6: triggers
        cyc(1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 32'h0, "R6 start without enable");
        rd(2'd1, "R6 start ignored");
        wr(2'd1, ctl_word(1'b0, 1'b0, 1'b1, 1'b1, 5'd3), "R6 trigger enables");
        cyc(1'b0, 1'b1, 1'b0, 2'd1, 1'b0, 32'h0, "R6 start");
        rd(2'd1, "R6 started");
        cyc(1'b0, 1'b1, 1'b1, 2'd1, 1'b0, 32'h0, "R6 both");
        rd(2'd1, "R6 stop wins");

        // R7: watermark auto-stop, beats a start trigger
        wr(2'd0, {29'h40, 1'b0, 2'b00}, "R7 pos");
        wr(2'd2, flow_word(29'h43, 1'b0, 1'b1), "R7 flow");
        wr(2'd1, ctl_word(1'b1, 1'b0, 1'b0, 1'b1, 5'd31), "R7 enable");
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0, "R7 approach");
        cyc(1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 32'h0, "R7 at watermark");
        rd(2'd1, "R7 stopped");
        rd(2'd0, "R7 pointer");

        // R8: auto-halt
        wr(2'd2, flow_word(29'h45, 1'b1, 1'b0), "R8 flow");
        wr(2'd1, ctl_word(1'b1, 1'b0, 1'b0, 1'b0, 5'd31), "R8 enable");
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 32'h0, "R8 run");
        rd(2'd1, "R8 halt sticky");

        // R9: software write collisions
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 1'b1, {29'h1234, 1'b0, 2'b00}, "R9 pos vs packet");
        rd(2'd0, "R9 pos written");
        wr(2'd1, ctl_word(1'b1, 1'b0, 1'b1, 1'b0, 5'd2), "R9 stop enable");
        cyc(1'b0, 1'b0, 1'b1, 2'd1, 1'b1, ctl_word(1'b1, 1'b0, 1'b1, 1'b0, 5'd2), "R9 ctl vs stop");
        rd(2'd1, "R9 ctl written");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r, d;
            logic [1:0]  s;
            logic        w;
            r = $urandom;
            s = 2'($urandom_range(0, 3));
            w = ($urandom_range(0, 99) < 6);
            d = $urandom;
            if (w && s == 2'd1) begin
                d[4:0] = ($urandom_range(0, 9) == 0) ? 5'(28 + $urandom_range(0, 3))
                                                      : 5'($urandom_range(0, 5));
                d[31]  = ($urandom_range(0, 3) != 0);
            end
            if (w && s == 2'd2) d[31:3] = {23'b0, d[8:3]};
            if (w && s == 2'd0) d[31:3] = {23'b0, d[8:3]};
            cyc(r[0] | r[1], (r[7:4] == 4'd0), (r[11:8] == 4'd0), s, w, d, "R2 random read");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule